// File: doc/BRIEF.md
# Canvas descriptor table

This block keeps a table of pixel-buffer descriptors that video engines address by a small index instead of by physical address. Each descriptor carries a base address and a line width (both in 8-byte units), a height in lines, a wrap mode, a tiling (block) mode and a byte-swap mode. Software fills a descriptor in three bus writes. It writes a low data word and a high data word into staging registers, then writes the control register with an index and a commit bit. The same control register can instead pull an existing entry back into the staging registers, where software can read it.

Clients fetch descriptors through a separate lookup port. They present an index, and the unpacked fields of that entry appear combinationally on the same cycle. Reset invalidates the whole table, so an entry that was never committed reads as all zeros on both the lookup port and the readback path. The table depth is a parameter, with 256 entries by default.

Top module: `canvas_lut`

## Requirements
- R1: After reset, every lookup index returns all-zero fields, and reads of the low word (0x00), high word (0x04) and control register (0x08) return 0.
- R2: A write to byte offset 0x00 or 0x04 replaces the staged low or high word, which reads back unchanged, and leaves every table entry untouched.
- R3: A control write (offset 0x08) with bit 9 set stores the staged {high, low} pair into the entry named by bits [7:0]. The lookup port shows the new entry from the cycle after the write.
- R4: Lookup fields decode as follows: base = low[28:0]; width = {high[8:0], low[31:29]} (12 bits); height = high[21:9]; wrap = high[23:22] (0 none, bit 0 X, bit 1 Y); block mode = high[25:24] (0 linear, 1 32x32 tiles, 2 64x64 tiles); endian = high[29:26].
- R5: A control write with bit 8 set and bit 9 clear copies the indexed entry into the staged low and high words.
- R6: When bits 8 and 9 are both set, the commit happens and the load is ignored, so the staged words keep their values.
- R7: A read of the high word after a commit returns the value just committed, so software can use it as a flush.
- R8: A control write with bits 8 and 9 clear changes neither the table nor the staged words.
- R9: Read data and a one-cycle valid strobe appear on the cycle after a read request. Reading the control register returns the last written index in bits [7:0] and 0 above. Offset 0x0C and misaligned addresses read as 0, and writes to them are ignored.
- R10: An entry that was never committed returns zeros on lookup and on load. A commit changes only its own entry, including the last index, 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| lk_idx | input | 8 | Lookup index |
| lk_base | output | 29 | Base address in 8-byte units |
| lk_width | output | 12 | Line width in 8-byte units |
| lk_height | output | 13 | Height in lines |
| lk_wrap | output | 2 | Wrap mode |
| lk_blk | output | 2 | Block (tiling) mode |
| lk_endian | output | 4 | Byte-swap mode |

## Verification
Two events can land on the same cycle: a commit and a load in one control write, and a commit to the very index the lookup port is watching. The bench drives control writes with both bits set on indices whose stored entry differs from the staged words. It then judges from the staged words read back that the write won and the stale entry was not loaded. It also holds the lookup index on the committed entry across the write edge and checks that the old fields stay visible until that edge and the new fields appear just after it. Constrained random traffic on a narrow index set repeats these collisions against a bench-side model.

// File: rtl/canvas_pkg.sv
package canvas_pkg;
  localparam int WORD_W   = 32;
  localparam int BASE_W   = 29;
  localparam int WLO_W    = 3;
  localparam int WHI_W    = 9;
  localparam int WIDTH_W  = WLO_W + WHI_W;
  localparam int HGT_LSB  = 9;
  localparam int HGT_W    = 13;
  localparam int WRAP_LSB = 22;
  localparam int WRAP_W   = 2;
  localparam int BLK_LSB  = 24;
  localparam int BLK_W    = 2;
  localparam int END_LSB  = 26;
  localparam int END_W    = 4;
  // bits of the high word that carry descriptor fields
  localparam int HI_USED  = END_LSB + END_W;
  localparam int LK_W     = WORD_W + HI_USED;

  localparam int CTL_RD_BIT = 8;
  localparam int CTL_WR_BIT = 9;

  typedef enum logic [1:0] {
    REG_LO  = 2'd0,
    REG_HI  = 2'd1,
    REG_CTL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [BASE_W-1:0]  base;
    logic [WIDTH_W-1:0] width;
    logic [HGT_W-1:0]   height;
    logic [WRAP_W-1:0]  wrap;
    logic [BLK_W-1:0]   blk;
    logic [END_W-1:0]   endian;
  } desc_t;
endpackage

// File: rtl/canvas_regs.sv
module canvas_regs
  import canvas_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [3:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [WORD_W-1:0] stage_lo,
  output logic [WORD_W-1:0] stage_hi,
  output logic              commit,
  output logic [IDX_W-1:0]  cmd_idx,
  input  logic [2*WORD_W-1:0] rb_word
);
  localparam int PAD_W = WORD_W - IDX_W;

  reg_sel_e          sel;
  logic              ctl_hit;
  logic              load;
  logic [IDX_W-1:0]  last_idx;

  always_comb begin
    if (bus_addr[1:0] != 2'b00) sel = REG_NONE;
    else                        sel = reg_sel_e'(bus_addr[3:2]);
  end

  assign ctl_hit = bus_we && (sel == REG_CTL);
  assign commit  = ctl_hit && bus_wdata[CTL_WR_BIT];
  // the write wins when both enables are set
  assign load    = ctl_hit && bus_wdata[CTL_RD_BIT] && !bus_wdata[CTL_WR_BIT];
  assign cmd_idx = bus_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo <= '0;
      stage_hi <= '0;
      last_idx <= '0;
    end else begin
      if (bus_we && sel == REG_LO) stage_lo <= bus_wdata;
      if (bus_we && sel == REG_HI) stage_hi <= bus_wdata;
      if (load) begin
        stage_lo <= rb_word[WORD_W-1:0];
        stage_hi <= rb_word[2*WORD_W-1:WORD_W];
      end
      if (ctl_hit) last_idx <= cmd_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) begin
        case (sel)
          REG_LO:  bus_rdata <= stage_lo;
          REG_HI:  bus_rdata <= stage_hi;
          REG_CTL: bus_rdata <= {{PAD_W{1'b0}}, last_idx};
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/canvas_store.sv
module canvas_store
  import canvas_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2*WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]    rb_idx,
  output logic [2*WORD_W-1:0] rb_word,
  input  logic [IDX_W-1:0]    lk_idx,
  output logic [LK_W-1:0]     lk_word
);
  // payload array carries no reset; a valid vector masks stale contents
  logic [2*WORD_W-1:0] mem [ENTRIES];
  logic [ENTRIES-1:0]  vld;
  logic [2*WORD_W-1:0] lk_full;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  assign rb_word = vld[rb_idx] ? mem[rb_idx] : '0;
  assign lk_full = vld[lk_idx] ? mem[lk_idx] : '0;
  assign lk_word = lk_full[LK_W-1:0];
endmodule

// File: rtl/canvas_unpack.sv
module canvas_unpack
  import canvas_pkg::*;
(
  input  logic [LK_W-1:0] word,
  output desc_t           desc
);
  logic [WORD_W-1:0]  lo;
  logic [HI_USED-1:0] hi;

  assign lo = word[WORD_W-1:0];
  assign hi = word[LK_W-1:WORD_W];

  assign desc.base   = lo[BASE_W-1:0];
  assign desc.width  = {hi[WHI_W-1:0], lo[WORD_W-1:BASE_W]};
  assign desc.height = hi[HGT_LSB +: HGT_W];
  assign desc.wrap   = hi[WRAP_LSB +: WRAP_W];
  assign desc.blk    = hi[BLK_LSB +: BLK_W];
  assign desc.endian = hi[END_LSB +: END_W];
endmodule

// File: rtl/canvas_lut.sv
module canvas_lut
  import canvas_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [3:0]         bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [BASE_W-1:0]  lk_base,
  output logic [WIDTH_W-1:0] lk_width,
  output logic [HGT_W-1:0]   lk_height,
  output logic [WRAP_W-1:0]  lk_wrap,
  output logic [BLK_W-1:0]   lk_blk,
  output logic [END_W-1:0]   lk_endian
);
  logic [WORD_W-1:0]   stage_lo;
  logic [WORD_W-1:0]   stage_hi;
  logic                commit;
  logic [IDX_W-1:0]    cmd_idx;
  logic [2*WORD_W-1:0] rb_word;
  logic [LK_W-1:0]     lk_word;
  desc_t               lk_desc;

  canvas_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .stage_lo(stage_lo), .stage_hi(stage_hi),
    .commit(commit), .cmd_idx(cmd_idx), .rb_word(rb_word)
  );

  canvas_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(commit), .wr_idx(cmd_idx), .wr_word({stage_hi, stage_lo}),
    .rb_idx(cmd_idx), .rb_word(rb_word),
    .lk_idx(lk_idx), .lk_word(lk_word)
  );

  canvas_unpack u_unpack (.word(lk_word), .desc(lk_desc));

  assign lk_base   = lk_desc.base;
  assign lk_width  = lk_desc.width;
  assign lk_height = lk_desc.height;
  assign lk_wrap   = lk_desc.wrap;
  assign lk_blk    = lk_desc.blk;
  assign lk_endian = lk_desc.endian;
endmodule

// File: rtl/canvas_lut_chk.sv
module canvas_lut_chk
  import canvas_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic               bus_re,
  input logic [3:0]         bus_addr,
  input logic [WORD_W-1:0]  bus_wdata,
  input logic               bus_rvalid,
  input logic [IDX_W-1:0]   lk_idx,
  input logic [BASE_W-1:0]  lk_base,
  input logic [WIDTH_W-1:0] lk_width,
  input logic [HGT_W-1:0]   lk_height,
  input logic [WRAP_W-1:0]  lk_wrap,
  input logic [BLK_W-1:0]   lk_blk,
  input logic [END_W-1:0]   lk_endian,
  input logic [WORD_W-1:0]  stage_lo,
  input logic [WORD_W-1:0]  stage_hi
);
  logic ctl_wr, wr_bit, rd_bit, lo_wr;
  assign ctl_wr = bus_we && bus_addr == 4'h8;
  assign wr_bit = bus_wdata[CTL_WR_BIT];
  assign rd_bit = bus_wdata[CTL_RD_BIT];
  assign lo_wr  = bus_we && bus_addr == 4'h0;

  // R9
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid);

  // R9
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> !bus_rvalid);

  // R2
  stage_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> stage_lo == $past(bus_wdata));

  // R3
  commit_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_bit && lk_idx == bus_wdata[IDX_W-1:0]) |=>
      (!$stable(lk_idx) ||
       (lk_base == $past(stage_lo[BASE_W-1:0]) &&
        lk_height == $past(stage_hi[HGT_LSB +: HGT_W]))));

  // R6
  both_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_bit && rd_bit) |=> ($stable(stage_lo) && $stable(stage_hi)));

  // R8
  no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && wr_bit) |=>
      (!$stable(lk_idx) ||
       ($stable(lk_base) && $stable(lk_width) && $stable(lk_height) &&
        $stable(lk_wrap) && $stable(lk_blk) && $stable(lk_endian))));
endmodule

bind canvas_lut canvas_lut_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .lk_idx(lk_idx), .lk_base(lk_base), .lk_width(lk_width),
  .lk_height(lk_height), .lk_wrap(lk_wrap), .lk_blk(lk_blk),
  .lk_endian(lk_endian), .stage_lo(stage_lo), .stage_hi(stage_hi)
);

// File: tb/canvas_lut_tb.sv
module canvas_lut_tb;
  localparam int CLK_P = 10;
  localparam int N_ENT = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  lk_idx = '0;
  logic [28:0] lk_base;
  logic [11:0] lk_width;
  logic [12:0] lk_height;
  logic [1:0]  lk_wrap, lk_blk;
  logic [3:0]  lk_endian;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [31:0] ref_lo [N_ENT];
  logic [31:0] ref_hi [N_ENT];
  logic [31:0] stg_lo = '0, stg_hi = '0;
  logic [7:0]  last_idx = '0;

  always #(CLK_P/2) clk = ~clk;

  canvas_lut u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .lk_idx(lk_idx), .lk_base(lk_base),
    .lk_width(lk_width), .lk_height(lk_height), .lk_wrap(lk_wrap),
    .lk_blk(lk_blk), .lk_endian(lk_endian)
  );

  function automatic logic [61:0] exp_fields(input logic [31:0] lo, input logic [31:0] hi);
    return {lo[28:0], hi[8:0], lo[31:29], hi[21:9], hi[23:22], hi[25:24], hi[29:26]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
    chk("R9 rvalid", {63'd0, bus_rvalid}, 64'd1);
  endtask

  task automatic chk_lk(input string req, input logic [7:0] idx);
    lk_idx = idx;
    #1;
    chk(req, {2'b0, lk_base, lk_width, lk_height, lk_wrap, lk_blk, lk_endian},
        {2'b0, exp_fields(ref_lo[idx], ref_hi[idx])});
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, {32'd0, v}, {32'd0, exp});
  endtask

  // model of a control write
  task automatic ctl(input logic [7:0] idx, input bit we, input bit re, input logic [21:0] junk);
    wr(4'h8, {junk, we, re, idx});
    if (we) begin
      ref_lo[idx] = stg_lo; ref_hi[idx] = stg_hi;
    end else if (re) begin
      stg_lo = ref_lo[idx]; stg_hi = ref_hi[idx];
    end
    last_idx = idx;
  endtask

  task automatic stage(input logic [31:0] lo, input logic [31:0] hi);
    wr(4'h0, lo); stg_lo = lo;
    wr(4'h4, hi); stg_hi = hi;
  endtask

  function automatic logic [7:0] pick_idx();
    logic [3:0] r = 4'($urandom % 10);
    if (r < 8) return {5'd0, r[2:0]};
    if (r == 8) return 8'd255;
    return 8'($urandom);
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lo, hi;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < N_ENT; i++) begin ref_lo[i] = '0; ref_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_lk("R1 lookup 0", 8'd0);
    chk_lk("R1 lookup 255", 8'd255);
    chk_reg("R1 lo", 4'h0, 32'd0);
    chk_reg("R1 hi", 4'h4, 32'd0);
    chk_reg("R1 ctl", 4'h8, 32'd0);

    // R2 staging only
    stage(32'hDEAD_BEEF, 32'h1234_5678);
    chk_reg("R2 lo readback", 4'h0, 32'hDEAD_BEEF);
    chk_reg("R2 hi readback", 4'h4, 32'h1234_5678);
    chk_lk("R2 table untouched", 8'd5);

    // R4 field decode with known values
    lo = {3'b101, 29'h1ABC_DEF1};
    hi = {2'b11, 4'hF, 2'd1, 2'd2, 13'h1234, 9'h157};
    stage(lo, hi);
    ctl(8'd5, 1, 0, 22'h0);
    lk_idx = 8'd5; #1;
    chk("R4 base", {35'd0, lk_base}, {35'd0, 29'h1ABC_DEF1});
    chk("R4 width", {52'd0, lk_width}, {52'd0, 12'h157 << 3 | 12'd5});
    chk("R4 height", {51'd0, lk_height}, {51'd0, 13'h1234});
    chk("R4 wrap", {62'd0, lk_wrap}, 64'd2);
    chk("R4 blk", {62'd0, lk_blk}, 64'd1);
    chk("R4 endian", {60'd0, lk_endian}, 64'hF);
    chk_lk("R3 commit", 8'd5);
    // R7 flush read
    chk_reg("R7 hi after commit", 4'h4, hi);
    chk_lk("R10 neighbour 4", 8'd4);
    chk_lk("R10 neighbour 6", 8'd6);

    // R3 lookup held on index across the commit edge
    stage(32'h0000_0011, 32'h0000_0222);
    lk_idx = 8'd5;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h0000_0205;
    #1;
    chk("R3 old before edge", {2'b0, lk_base, lk_width, lk_height, lk_wrap, lk_blk, lk_endian},
        {2'b0, exp_fields(ref_lo[5], ref_hi[5])});
    @(negedge clk);
    bus_we = 1'b0;
    ref_lo[5] = stg_lo; ref_hi[5] = stg_hi; last_idx = 8'd5;
    chk_lk("R3 new after edge", 8'd5);

    // R5 load into staging
    stage(32'hAAAA_0000, 32'hBBBB_0000);
    ctl(8'd5, 0, 1, 22'h0);
    chk_reg("R5 lo loaded", 4'h0, 32'h0000_0011);
    chk_reg("R5 hi loaded", 4'h4, 32'h0000_0222);
    chk_reg("R9 ctl index", 4'h8, 32'd5);
    ctl(8'd9, 0, 1, 22'h0);
    chk_reg("R10 load unwritten", 4'h0, 32'd0);

    // R6 both enables
    stage(32'hCAFE_F00D, 32'h0BAD_F00D);
    ctl(8'd5, 1, 1, 22'h0);
    chk_reg("R6 lo kept", 4'h0, 32'hCAFE_F00D);
    chk_reg("R6 hi kept", 4'h4, 32'h0BAD_F00D);
    chk_lk("R6 committed", 8'd5);

    // R8 neither bit
    stage(32'h1111_1111, 32'h2222_2222);
    ctl(8'd7, 0, 0, 22'h3FFFFF);
    chk_lk("R8 table untouched", 8'd7);
    chk_reg("R8 lo kept", 4'h0, 32'h1111_1111);

    // R9 unmapped / misaligned
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h1, 32'h5555_5555);
    chk_reg("R9 unmapped read", 4'hC, 32'd0);
    chk_reg("R9 misaligned read", 4'h2, 32'd0);
    chk_reg("R9 lo after ignored", 4'h0, 32'h1111_1111);

    // R10 last index
    ctl(8'd255, 1, 0, 22'h0);
    chk_lk("R10 entry 255", 8'd255);
    chk_lk("R10 entry 254", 8'd254);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      case ($urandom % 6)
        0: begin v = $urandom; wr(4'h0, v); stg_lo = v; end
        1: begin v = $urandom; wr(4'h4, v); stg_hi = v; end
        2, 3: ctl(pick_idx(), 1'($urandom), 1'($urandom), 22'($urandom));
        4: begin
          case ($urandom % 3)
            0: chk_reg("R2 random lo", 4'h0, stg_lo);
            1: chk_reg("R7 random hi", 4'h4, stg_hi);
            default: chk_reg("R9 random ctl", 4'h8, {24'd0, last_idx});
          endcase
        end
        default: chk_lk("R3 random lookup", pick_idx());
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule